// File: doc/BRIEF.md
# Serial Receiver Wakeup Detector

This block sits beside a UART receiver and decides when a receiver that has been put to sleep returns to normal operation. Software, or a protocol engine, asks for sleep with a one-cycle request. While the receiver is asleep, received characters are held back from the consumer. Two wake conditions are available, and one control input picks between them. The first is an address mark: the top data bit of a received character is 1. The second is an idle line: a full character time of consecutive logic-1 bits.

The block does not sample the line itself. It takes the already-sampled line value together with a bit-time strobe, start-bit and stop-bit event pulses, and the character-valid strobe with its data. Idle counting can begin in one of two places: right after the start bit, or only after the stop bit. The first choice counts data and stop bits of a character toward idle. A run of ones late in a character can therefore produce an early idle detection. This effect is intentional and is kept.

Top module: `rx_wake_detector`

## Requirements
- R1: After reset the detector is awake (`asleep` = 0), and `wakePulse`, `idleDetected` and `fwdValid` are 0.
- R2: A `sleepReq` pulse while awake sets `asleep` on the next clock edge. While awake, every `charValid` is forwarded one cycle later on `fwdValid`, and `fwdData` carries the same 9-bit value.
- R3: While asleep, a received character that does not cause a wake produces no `fwdValid`, and `asleep` stays 1.
- R4: With `wakeSel` = 1 (address mark), a character received while asleep wakes the block only if its top bit is 1. The top bit is bit 7 when `nineBit` = 0 and bit 8 when `nineBit` = 1. The waking character is forwarded in the same cycle as `wakePulse`.
- R5: With `wakeSel` = 0 (idle line), a character with its top bit set does not wake the block. An idle detection while asleep wakes it, one cycle after the bit strobe that completes the idle count.
- R6: `idleDetected` pulses for one cycle, one cycle after the strobe of the counted logic-1 bit that completes the count. The count is 10 bits when `nineBit` = 0 and 11 when `nineBit` = 1. It fires at most once per unbroken run of ones.
- R7: Any bit strobe with `rxBit` = 0 clears the idle count.
- R8: With `idleAfterStop` = 0, counting restarts after each start bit, and the data and stop bits of a character count. With `idleAfterStop` = 1, counting restarts only after the stop bit. As a result, an all-ones 8-bit character followed by a single idle bit gives an idle detection only in the first mode.
- R9: `wakePulse` lasts exactly one cycle, and `asleep` is 0 in that cycle.
- R10: With `wakeSel` = 1, an idle detection while asleep does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Sampled line value, valid with `bitStrobe` |
| bitStrobe | input | 1 | One cycle per received bit time |
| startPulse | input | 1 | Marks the strobe of a start bit |
| stopPulse | input | 1 | Marks the strobe of a stop bit |
| charValid | input | 1 | A received character is available |
| charData | input | 9 | Received character, bit 8 used only in 9-bit mode |
| sleepReq | input | 1 | Request to enter the sleeping state |
| wakeSel | input | 1 | 1 = address-mark wake, 0 = idle-line wake |
| idleAfterStop | input | 1 | 1 = idle count starts after stop bit, 0 = after start bit |
| nineBit | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| wakePulse | output | 1 | One-cycle wake event |
| asleep | output | 1 | Sleeping-state flag |
| idleDetected | output | 1 | One-cycle idle-character detection |
| fwdValid | output | 1 | Forwarded character strobe |
| fwdData | output | 9 | Forwarded character |

## Verification
The hardest situation to reach is the false idle caused by counting from the start bit. The bench has to build a frame whose data bits and stop bit are all ones, follow it with exactly one idle bit, and then compare the two counting origins on the same waveform. It does this by driving frames bit by bit through one task, which also produces idle gaps of exact length. The same mechanism places a lone zero bit in the middle of a run, and checks the boundary one bit before and at the 10- and 11-bit limits.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic fwdEn;
  } rxw_ctl_t;

  // datapath -> control event strobes
  typedef struct packed {
    logic idleHit;
    logic markHit;
  } rxw_stat_t;
endpackage

// File: rtl/rxw_datapath.sv
module rxw_datapath
  import rxw_pkg::*;
#(
  parameter int BASE_BITS   = 8,
  parameter int FRAME_EXTRA = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxBit,
  input  logic                 bitStrobe,
  input  logic                 startPulse,
  input  logic                 stopPulse,
  input  logic                 charValid,
  input  logic [BASE_BITS:0]   charData,
  input  logic                 idleAfterStop,
  input  logic                 nineBit,
  input  rxw_ctl_t             ctl,
  output rxw_stat_t            stat,
  output logic                 idleDetected,
  output logic                 fwdValid,
  output logic [BASE_BITS:0]   fwdData
);
  localparam int IDLE_SHORT = BASE_BITS + FRAME_EXTRA;
  localparam int IDLE_LONG  = IDLE_SHORT + 1;
  localparam int CNT_W      = $clog2(IDLE_LONG + 1);

  logic [CNT_W-1:0] oneCnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] idleLimit;
  logic             armed;
  logic             done;
  logic             stopRearm;
  logic             countable;
  logic             idleHitNow;
  logic             topBit;

  assign idleLimit  = nineBit ? CNT_W'(IDLE_LONG) : CNT_W'(IDLE_SHORT);
  assign cntNext    = oneCnt + 1'b1;
  assign stopRearm  = stopPulse && idleAfterStop;
  assign countable  = bitStrobe && !startPulse && rxBit && !stopRearm && armed && !done;
  assign idleHitNow = countable && (cntNext == idleLimit);
  assign topBit     = nineBit ? charData[BASE_BITS] : charData[BASE_BITS-1];

  assign stat.idleHit = idleHitNow;
  assign stat.markHit = charValid && topBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oneCnt       <= '0;
      armed        <= 1'b1;
      done         <= 1'b0;
      idleDetected <= 1'b0;
      fwdValid     <= 1'b0;
      fwdData      <= '0;
    end else begin
      idleDetected <= idleHitNow;
      fwdValid     <= charValid && ctl.fwdEn;
      if (charValid && ctl.fwdEn) fwdData <= charData;
      if (bitStrobe) begin
        if (startPulse) begin
          oneCnt <= '0;
          armed  <= !idleAfterStop;
          done   <= 1'b0;
        end else if (!rxBit) begin
          oneCnt <= '0;
          done   <= 1'b0;
        end else if (stopRearm) begin
          oneCnt <= '0;
          armed  <= 1'b1;
        end else if (countable) begin
          oneCnt <= cntNext;
          if (idleHitNow) done <= 1'b1;
        end
      end
    end
  end

  assert_idle_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    idleDetected |=> !idleDetected) else $error("idle pulse longer than one cycle");
  assert_idle_from_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    idleDetected |-> $past(bitStrobe && rxBit)) else $error("idle without a one bit");
  assert_fwd_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> $past(charValid)) else $error("forward without character");
endmodule

// File: rtl/rxw_control.sv
module rxw_control
  import rxw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  input  logic      wakeSel,
  input  rxw_stat_t stat,
  output rxw_ctl_t  ctl,
  output logic      wakePulse,
  output logic      asleep
);
  logic wakeNow;

  assign wakeNow   = asleep && (wakeSel ? stat.markHit : stat.idleHit);
  assign ctl.fwdEn = !asleep || (wakeSel && stat.markHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asleep    <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= wakeNow;
      if (wakeNow)       asleep <= 1'b0;
      else if (sleepReq) asleep <= 1'b1;
    end
  end

  assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!asleep && $past(asleep))) else $error("wake without leaving sleep");
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse) else $error("wake pulse too long");
  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(sleepReq)) else $error("sleep without request");
endmodule

// File: rtl/rx_wake_detector.sv
module rx_wake_detector
  import rxw_pkg::*;
#(
  parameter int BASE_BITS   = 8,
  parameter int FRAME_EXTRA = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxBit,
  input  logic               bitStrobe,
  input  logic               startPulse,
  input  logic               stopPulse,
  input  logic               charValid,
  input  logic [BASE_BITS:0] charData,
  input  logic               sleepReq,
  input  logic               wakeSel,
  input  logic               idleAfterStop,
  input  logic               nineBit,
  output logic               wakePulse,
  output logic               asleep,
  output logic               idleDetected,
  output logic               fwdValid,
  output logic [BASE_BITS:0] fwdData
);
  rxw_ctl_t  ctl;
  rxw_stat_t stat;

  rxw_datapath #(.BASE_BITS(BASE_BITS), .FRAME_EXTRA(FRAME_EXTRA)) i_datapath (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .bitStrobe(bitStrobe),
    .startPulse(startPulse), .stopPulse(stopPulse), .charValid(charValid),
    .charData(charData), .idleAfterStop(idleAfterStop), .nineBit(nineBit),
    .ctl(ctl), .stat(stat), .idleDetected(idleDetected),
    .fwdValid(fwdValid), .fwdData(fwdData)
  );

  rxw_control i_control (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeSel(wakeSel),
    .stat(stat), .ctl(ctl), .wakePulse(wakePulse), .asleep(asleep)
  );

  assert_no_fwd_asleep_R3: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (!$past(asleep) || wakePulse)) else $error("forward while asleep");
  assert_mark_forward_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wakePulse && $past(wakeSel)) |-> fwdValid) else $error("waking char not forwarded");
endmodule

// File: tb/test_rx_wake_detector.sv
module test_rx_wake_detector;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxBit = 1'b1, bitStrobe = 1'b0, startPulse = 1'b0, stopPulse = 1'b0;
  logic charValid = 1'b0;
  logic [8:0] charData = '0;
  logic sleepReq = 1'b0, wakeSel = 1'b0, idleAfterStop = 1'b0, nineBit = 1'b0;
  logic wakePulse, asleep, idleDetected, fwdValid;
  logic [8:0] fwdData;

  int checks = 0, errors = 0;
  int wakeCnt = 0, idleCnt = 0, fwdCnt = 0;
  logic [8:0] lastFwd = '0;

  always #5 clk = ~clk;

  rx_wake_detector i_rx_wake_detector (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .bitStrobe(bitStrobe),
    .startPulse(startPulse), .stopPulse(stopPulse), .charValid(charValid),
    .charData(charData), .sleepReq(sleepReq), .wakeSel(wakeSel),
    .idleAfterStop(idleAfterStop), .nineBit(nineBit), .wakePulse(wakePulse),
    .asleep(asleep), .idleDetected(idleDetected), .fwdValid(fwdValid), .fwdData(fwdData)
  );

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (wakePulse) wakeCnt++;
      if (idleDetected) idleCnt++;
      if (fwdValid) begin fwdCnt++; lastFwd = fwdData; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(logic b, logic st, logic sp, logic cv, logic [8:0] d);
    rxBit = b; bitStrobe = 1'b1; startPulse = st; stopPulse = sp;
    charValid = cv; charData = d;
    @(negedge clk);
    bitStrobe = 1'b0; startPulse = 1'b0; stopPulse = 1'b0; charValid = 1'b0; rxBit = 1'b1;
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic frame(logic [8:0] d);
    step(1'b0, 1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < (nineBit ? 9 : 8); i++) step(d[i], 1'b0, 1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 1'b1, 1'b1, d);
  endtask

  task automatic goSleep();
    sleepReq = 1'b1; @(negedge clk); sleepReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic testReset();
    chk("R1 asleep", asleep, 0); chk("R1 wakePulse", wakePulse, 0);
    chk("R1 idleDetected", idleDetected, 0); chk("R1 fwdValid", fwdValid, 0);
  endtask

  task automatic testAwakeForward();
    int f0 = fwdCnt;
    frame(9'h035);
    chk("R2 forwarded count", fwdCnt - f0, 1);
    chk("R2 forwarded data", lastFwd, 9'h035);
    goSleep();
    chk("R2 asleep after request", asleep, 1);
  endtask

  task automatic testMarkWake8();
    int f0 = fwdCnt, w0 = wakeCnt;
    wakeSel = 1'b1; nineBit = 1'b0;
    frame(9'h07F);
    chk("R3 no forward while asleep", fwdCnt - f0, 0);
    chk("R3 still asleep", asleep, 1);
    frame(9'h080);
    chk("R4 wake on bit7", wakeCnt - w0, 1);
    chk("R4 waking char forwarded", lastFwd, 9'h080);
    chk("R4 awake", asleep, 0);
  endtask

  task automatic testMarkWake9();
    int w0 = wakeCnt;
    nineBit = 1'b1; goSleep();
    frame(9'h080);
    chk("R4 nine-bit bit7 no wake", wakeCnt - w0, 0);
    frame(9'h100);
    chk("R4 nine-bit bit8 wakes", wakeCnt - w0, 1);
    chk("R4 nine-bit data", lastFwd, 9'h100);
    nineBit = 1'b0;
  endtask

  task automatic testIdleWake();
    int w0 = wakeCnt, f0 = fwdCnt, i0 = idleCnt;
    wakeSel = 1'b0; idleAfterStop = 1'b1; goSleep();
    frame(9'h080);
    chk("R5 mark ignored in idle mode", wakeCnt - w0, 0);
    chk("R3 char held", fwdCnt - f0, 0);
    gap(9);
    chk("R8 after-stop 9 bits no idle", idleCnt - i0, 0);
    gap(1);
    chk("R6 idle at 10 bits", idleCnt - i0, 1);
    chk("R5 idle wakes", wakeCnt - w0, 1);
    chk("R9 awake after wake", asleep, 0);
  endtask

  task automatic testFalseIdle();
    int i0;
    idleAfterStop = 1'b0; i0 = idleCnt;
    frame(9'h0FF); gap(1);
    chk("R8 after-start false idle", idleCnt - i0, 1);
    idleAfterStop = 1'b1; i0 = idleCnt;
    frame(9'h0FF); gap(1);
    chk("R8 after-stop no false idle", idleCnt - i0, 0);
  endtask

  task automatic testZeroClears();
    int i0;
    idleAfterStop = 1'b0;
    frame(9'h000); i0 = idleCnt;
    gap(4); step(1'b0, 1'b0, 1'b0, 1'b0, '0); gap(9);
    chk("R7 zero clears count", idleCnt - i0, 0);
    gap(1);
    chk("R7 idle after fresh run", idleCnt - i0, 1);
    gap(20);
    chk("R6 single pulse per run", idleCnt - i0, 1);
  endtask

  task automatic testIdleNoMarkWake();
    int w0 = wakeCnt, i0 = idleCnt;
    wakeSel = 1'b1; goSleep();
    frame(9'h000); gap(15);
    chk("R10 idle seen", idleCnt - i0, 1);
    chk("R10 no wake on idle", wakeCnt - w0, 0);
    chk("R10 still asleep", asleep, 1);
    frame(9'h0C1);
    chk("R4 later mark wakes", wakeCnt - w0, 1);
  endtask

  task automatic testNineIdle();
    int i0;
    nineBit = 1'b1; idleAfterStop = 1'b1; wakeSel = 1'b0;
    frame(9'h1FF); i0 = idleCnt;
    gap(10);
    chk("R6 nine-bit 10 bits no idle", idleCnt - i0, 0);
    gap(1);
    chk("R6 nine-bit idle at 11", idleCnt - i0, 1);
    nineBit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAwakeForward();
    testMarkWake8();
    testMarkWake9();
    testIdleWake();
    testFalseIdle();
    testZeroClears();
    testIdleNoMarkWake();
    testNineIdle();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule